// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block sits between a simple host request port and a single-data-rate SDRAM with four banks and a 16-bit data bus. The host presents one word access at a time: a read or a write, a word address, write data and a byte mask, all under a valid/ready handshake. The block turns each access into an ACTIVE command followed by a READ or WRITE with auto precharge. It returns read data after the CAS latency that was programmed into the memory.

After reset the block runs the power-up sequence on its own: a parameterised stretch of NOPs, a precharge of every bank, two auto-refresh commands, and a mode-register load. The mode-register load programs a burst of one and a CAS latency of 2 or 3, picked by a runtime input. From then on a refresh timer requests an auto refresh every `REF_INTERVAL` cycles. At 50 MHz this is 780 cycles, or 15.6 µs, which gives 4096 refreshes in 64 ms. A pending refresh is served before the next host access, once the access in flight has finished.

Top module: `sdr_cmd_ctrl`

## Requirements
- R1: After reset the command bus carries only NOP for at least `INIT_CYCLES` cycles, with CKE high from the first clock after reset. It then carries PRECHARGE with address bit 10 set, then two AUTO REFRESH commands, then LOAD MODE. `req_ready` stays low until LOAD MODE has been issued, and no ACTIVE appears before it.
- R2: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as follows: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, LOAD MODE 0000.
- R3: An accepted request with `req_addr` = {bank[22:21], row[20:9], col[8:0]} produces ACTIVE with `sd_ba`=bank and `sd_addr`=row. Exactly `T_RCD` cycles later it produces READ or WRITE on the same bank, with `sd_addr` = {bit11=0, bit10=1 (auto precharge), bit9=0, col}.
- R4: The LOAD MODE address word holds the CAS latency in bits 6:4 (3 when `cas_lat3`=1, else 2), and every other bit is zero (burst length 1, sequential). `cas_lat3` is sampled only at LOAD MODE; later changes have no effect.
- R5: For a READ on the bus in cycle c, `sd_dq_in` is captured at the rising edge that ends cycle c+CL, and `rd_valid` is high for exactly one cycle, c+CL+1, with that word on `rd_data`.
- R6: WRITE drives `sd_dq_out` with the request data, `sd_dq_oe`=1 and `sd_dqm`=`req_mask`, where a mask bit of 1 suppresses that byte (bit 0 is the low byte). READ drives `sd_dqm`=00. `sd_dq_oe` is high in no other cycle.
- R7: After initialisation, consecutive AUTO REFRESH commands are spaced `REF_INTERVAL` cycles apart, within the length of one access.
- R8: A pending refresh wins over a waiting host request. Even under a host that never drops `req_valid`, refreshes keep the spacing of R7.
- R9: Command spacing: at least `T_RC` cycles after AUTO REFRESH and between two ACTIVE commands, and at least `T_RP` after PRECHARGE and `T_MRD` after LOAD MODE.
- R10: `req_ready` is high only when the sequencer is idle with no refresh pending. Each cycle with `req_valid` and `req_ready` both high yields exactly one ACTIVE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cas_lat3 | input | 1 | 1 selects CAS latency 3, 0 selects 2 (sampled at mode load) |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request accepted this cycle when valid |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 23 | Word address {bank, row, col} |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte mask, 1 suppresses the byte |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 16 | Read data |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, low active |
| sd_ras_n | output | 1 | Row strobe, low active |
| sd_cas_n | output | 1 | Column strobe, low active |
| sd_we_n | output | 1 | Write enable, low active |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 12 | Row / column / mode address |
| sd_dqm | output | 2 | Data mask |
| sd_dq_out | output | 16 | Write data to the pads |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | 16 | Read data from the pads |

## Verification
The hardest situation to reach from the ports is a refresh falling due while a request is already waiting or an access is in flight. Only there does the priority decision of R8 matter, and only there does the refresh spacing stretch. The bench reaches it by holding `req_valid` high with back-to-back reads for more than two refresh intervals, so that every refresh tick lands in a busy sequencer. It then checks the refresh spacing and that the count of accepted handshakes matches the count of ACTIVE commands. The CAS latency is checked by a memory model that drives read data for exactly one cycle, and this is done at both latencies across two resets.

// File: rtl/sdr_pkg.sv
// Shared command codes and sequencer states for the SDRAM command sequencer.
// Command code bit order is {cs_n, ras_n, cas_n, we_n}.
package sdr_pkg;

    typedef enum logic [3:0] {
        CMD_MODE = 4'b0000,
        CMD_REF  = 4'b0001,
        CMD_PRE  = 4'b0010,
        CMD_ACT  = 4'b0011,
        CMD_WR   = 4'b0100,
        CMD_RD   = 4'b0101,
        CMD_NOP  = 4'b0111
    } sdr_cmd_e;

    typedef enum logic [2:0] {
        ST_POWERUP,
        ST_PREALL,
        ST_REFRESH,
        ST_MODE,
        ST_IDLE,
        ST_ACCESS,
        ST_WAIT
    } seq_state_e;

endpackage

// File: rtl/sdr_refresh_timer.sv
// Refresh interval timer.
// Counts clock cycles while enabled and raises a sticky pending flag each
// time INTERVAL cycles have elapsed. The flag clears on ack.
// Assumes the sequencer acknowledges well within one interval.
module sdr_refresh_timer #(
    parameter int INTERVAL = 780
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic ack,
    output logic pend
);
    localparam int CW = $clog2(INTERVAL + 1);

    logic [CW-1:0] cnt;

    // Interval counter and sticky pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt  <= '0;
            pend <= 1'b0;
        end else if (cnt == CW'(INTERVAL - 1)) begin
            cnt  <= '0;
            pend <= 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
            if (ack) pend <= 1'b0;
        end
    end

    // Checker: how long the pending flag has waited for service.
    logic [CW-1:0] age;
    always_ff @(posedge clk) begin
        if (!rst_n || !pend) age <= '0;
        else if (age != CW'(INTERVAL)) age <= age + 1'b1;
    end

    a_r7_served_in_time: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> age < CW'(INTERVAL));

endmodule

// File: rtl/sdr_rd_capture.sv
// Read data capture.
// Tracks each READ placed on the bus and samples the data pins at the edge
// that ends cycle c+CL, where c is the cycle the READ is on the bus.
// Assumes a burst length of one and a CAS latency of 2 or 3.
module sdr_rd_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cl3,
    input  logic              rd_issued,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam int MAX_CL = 3;

    logic [MAX_CL-1:0] pipe;
    logic              take;

    // Age of each outstanding READ in cycles since it left the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[MAX_CL-2:0], rd_issued};
    end

    // Select the stage that matches the programmed latency.
    always_comb take = cl3 ? pipe[MAX_CL-1] : pipe[MAX_CL-2];

    // Register the sampled word and its valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= take;
            if (take) rd_data <= dq_in;
        end
    end

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    a_r5_latency_cl3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && cl3) |-> $past(rd_issued, 4));
    a_r5_latency_cl2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !cl3) |-> $past(rd_issued, 3));

endmodule

// File: rtl/sdr_seq.sv
// Command sequencer.
// Runs power-up initialisation, then serves refreshes and single host
// accesses as ACTIVE followed by READ/WRITE with auto precharge. A single
// down-counter with a return state times every gap between commands.
// Assumes all timing parameters are at least 2 cycles and ROW_W > 10.
module sdr_seq
    import sdr_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ROW_W       = 12,
    parameter int COL_W       = 9,
    parameter int BANK_W      = 2,
    parameter int INIT_CYCLES = 100,
    parameter int INIT_REFS   = 2,
    parameter int T_RCD       = 3,
    parameter int T_RP        = 3,
    parameter int T_RC        = 9,
    parameter int T_WR        = 2,
    parameter int T_MRD       = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cas_lat3,
    input  logic                              req_valid,
    output logic                              req_ready,
    input  logic                              req_write,
    input  logic [BANK_W+ROW_W+COL_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]                 req_wdata,
    input  logic [DATA_W/8-1:0]               req_mask,
    input  logic                              ref_pend,
    output logic                              ref_ack,
    output logic                              init_done,
    output logic                              cl3,
    output sdr_cmd_e                          cmd,
    output logic [BANK_W-1:0]                 ba,
    output logic [ROW_W-1:0]                  addr,
    output logic [DATA_W/8-1:0]               dqm,
    output logic [DATA_W-1:0]                 dq,
    output logic                              dq_oe
);
    localparam int ADDR_W = BANK_W + ROW_W + COL_W;
    localparam int MASK_W = DATA_W / 8;
    localparam int AP_BIT = 10;
    localparam int RD_GAP = (T_RP + 1 > T_RC - T_RCD) ? T_RP + 1 : T_RC - T_RCD;
    localparam int WR_GAP = (T_WR + T_RP > T_RC - T_RCD) ? T_WR + T_RP : T_RC - T_RCD;
    localparam int CW     = $clog2(INIT_CYCLES + T_RC + RD_GAP + WR_GAP + 2);
    localparam int IW     = $clog2(INIT_REFS + 1);

    seq_state_e        state, nxt;
    logic [CW-1:0]     cnt;
    logic [IW-1:0]     init_left;
    logic              wr_q;
    logic [BANK_W-1:0] bank_q;
    logic [COL_W-1:0]  col_q;
    logic [DATA_W-1:0] wdata_q;
    logic [MASK_W-1:0] mask_q;
    logic [ROW_W-1:0]  mode_word, col_word, all_word;

    // Handshake: accept only when idle and no refresh is owed.
    always_comb req_ready = (state == ST_IDLE) && !ref_pend;
    // A periodic refresh is acknowledged when it is issued.
    always_comb ref_ack = (state == ST_REFRESH) && init_done;

    // Address words for mode load, column access and precharge-all.
    always_comb begin
        mode_word         = '0;
        mode_word[6:4]    = cas_lat3 ? 3'd3 : 3'd2;
        col_word          = '0;
        col_word[COL_W-1:0] = col_q;
        col_word[AP_BIT]  = 1'b1;
        all_word          = '0;
        all_word[AP_BIT]  = 1'b1;
    end

    // Main sequencer: one command per cycle at most, NOP by default.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_POWERUP;
            nxt       <= ST_IDLE;
            cnt       <= CW'(INIT_CYCLES - 1);
            init_left <= '0;
            init_done <= 1'b0;
            cl3       <= 1'b1;
            wr_q      <= 1'b0;
            bank_q    <= '0;
            col_q     <= '0;
            wdata_q   <= '0;
            mask_q    <= '0;
            cmd       <= CMD_NOP;
            ba        <= '0;
            addr      <= '0;
            dqm       <= '0;
            dq        <= '0;
            dq_oe     <= 1'b0;
        end else begin
            cmd   <= CMD_NOP;
            ba    <= '0;
            addr  <= '0;
            dqm   <= '0;
            dq    <= '0;
            dq_oe <= 1'b0;
            case (state)
                ST_POWERUP: begin
                    if (cnt == '0) state <= ST_PREALL;
                    else           cnt   <= cnt - 1'b1;
                end
                ST_PREALL: begin
                    cmd       <= CMD_PRE;
                    addr      <= all_word;
                    init_left <= IW'(INIT_REFS);
                    cnt       <= CW'(T_RP - 2);
                    nxt       <= ST_REFRESH;
                    state     <= ST_WAIT;
                end
                ST_REFRESH: begin
                    cmd   <= CMD_REF;
                    cnt   <= CW'(T_RC - 2);
                    state <= ST_WAIT;
                    if (!init_done) begin
                        init_left <= init_left - 1'b1;
                        nxt <= (init_left == IW'(1)) ? ST_MODE : ST_REFRESH;
                    end else begin
                        nxt <= ST_IDLE;
                    end
                end
                ST_MODE: begin
                    cmd       <= CMD_MODE;
                    addr      <= mode_word;
                    cl3       <= cas_lat3;
                    init_done <= 1'b1;
                    cnt       <= CW'(T_MRD - 2);
                    nxt       <= ST_IDLE;
                    state     <= ST_WAIT;
                end
                ST_IDLE: begin
                    if (ref_pend) begin
                        state <= ST_REFRESH;
                    end else if (req_valid) begin
                        cmd     <= CMD_ACT;
                        ba      <= req_addr[ADDR_W-1 -: BANK_W];
                        addr    <= req_addr[COL_W +: ROW_W];
                        bank_q  <= req_addr[ADDR_W-1 -: BANK_W];
                        col_q   <= req_addr[COL_W-1:0];
                        wr_q    <= req_write;
                        wdata_q <= req_wdata;
                        mask_q  <= req_mask;
                        cnt     <= CW'(T_RCD - 2);
                        nxt     <= ST_ACCESS;
                        state   <= ST_WAIT;
                    end
                end
                ST_ACCESS: begin
                    cmd   <= wr_q ? CMD_WR : CMD_RD;
                    ba    <= bank_q;
                    addr  <= col_word;
                    dqm   <= wr_q ? mask_q : '0;
                    dq    <= wr_q ? wdata_q : '0;
                    dq_oe <= wr_q;
                    cnt   <= wr_q ? CW'(WR_GAP - 2) : CW'(RD_GAP - 2);
                    nxt   <= ST_IDLE;
                    state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (cnt == '0) state <= nxt;
                    else           cnt   <= cnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Checker: last non-NOP command and the cycles elapsed since it.
    sdr_cmd_e   chk_last;
    logic [7:0] chk_gap;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_last <= CMD_NOP;
            chk_gap  <= '0;
        end else if (cmd != CMD_NOP) begin
            chk_last <= cmd;
            chk_gap  <= 8'd1;
        end else if (chk_gap != 8'hFF) begin
            chk_gap <= chk_gap + 1'b1;
        end
    end

    a_r3_act_then_column: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_RD || cmd == CMD_WR) |-> (chk_last == CMD_ACT && chk_gap == 8'(T_RCD)));
    a_r9_refresh_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NOP && chk_last == CMD_REF) |-> chk_gap >= 8'(T_RC));
    a_r1_ready_after_init: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> init_done);
    a_r1_no_access_in_init: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !(cmd == CMD_ACT || cmd == CMD_RD || cmd == CMD_WR));
    a_r10_accept_gives_act: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> cmd == CMD_ACT);

endmodule

// File: rtl/sdr_cmd_ctrl.sv
// SDRAM command sequencer top.
// Wires the sequencer, the refresh timer and the read capture together and
// splits the command code onto the four strobe pins.
// Assumes a 16-bit SDRAM with four banks, 4096 rows and 512 columns.
module sdr_cmd_ctrl
    import sdr_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int ROW_W        = 12,
    parameter int COL_W        = 9,
    parameter int BANK_W       = 2,
    parameter int INIT_CYCLES  = 100,
    parameter int REF_INTERVAL = 780,
    parameter int T_RCD        = 3,
    parameter int T_RP         = 3,
    parameter int T_RC         = 9,
    parameter int T_WR         = 2,
    parameter int T_MRD        = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cas_lat3,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic                          req_write,
    input  logic [BANK_W+ROW_W+COL_W-1:0] req_addr,
    input  logic [DATA_W-1:0]             req_wdata,
    input  logic [DATA_W/8-1:0]           req_mask,
    output logic                          rd_valid,
    output logic [DATA_W-1:0]             rd_data,
    output logic                          sd_cke,
    output logic                          sd_cs_n,
    output logic                          sd_ras_n,
    output logic                          sd_cas_n,
    output logic                          sd_we_n,
    output logic [BANK_W-1:0]             sd_ba,
    output logic [ROW_W-1:0]              sd_addr,
    output logic [DATA_W/8-1:0]           sd_dqm,
    output logic [DATA_W-1:0]             sd_dq_out,
    output logic                          sd_dq_oe,
    input  logic [DATA_W-1:0]             sd_dq_in
);
    sdr_cmd_e cmd;
    logic     ref_pend, ref_ack, init_done, cl3;

    // Clock enable rises on the first edge after reset and stays high.
    always_ff @(posedge clk) begin
        if (!rst_n) sd_cke <= 1'b0;
        else        sd_cke <= 1'b1;
    end

    // Command code onto the strobe pins.
    always_comb {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

    sdr_refresh_timer #(
        .INTERVAL (REF_INTERVAL)
    ) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (init_done),
        .ack   (ref_ack),
        .pend  (ref_pend)
    );

    sdr_seq #(
        .DATA_W      (DATA_W),
        .ROW_W       (ROW_W),
        .COL_W       (COL_W),
        .BANK_W      (BANK_W),
        .INIT_CYCLES (INIT_CYCLES),
        .INIT_REFS   (2),
        .T_RCD       (T_RCD),
        .T_RP        (T_RP),
        .T_RC        (T_RC),
        .T_WR        (T_WR),
        .T_MRD       (T_MRD)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cas_lat3  (cas_lat3),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_mask  (req_mask),
        .ref_pend  (ref_pend),
        .ref_ack   (ref_ack),
        .init_done (init_done),
        .cl3       (cl3),
        .cmd       (cmd),
        .ba        (sd_ba),
        .addr      (sd_addr),
        .dqm       (sd_dqm),
        .dq        (sd_dq_out),
        .dq_oe     (sd_dq_oe)
    );

    sdr_rd_capture #(
        .DATA_W (DATA_W)
    ) i_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cl3       (cl3),
        .rd_issued (cmd == CMD_RD),
        .dq_in     (sd_dq_in),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

endmodule

// File: tb/test_sdr_cmd_ctrl.sv
// Directed bench for the SDRAM command sequencer. A bus monitor with a small
// memory model checks protocol and timing; one task per scenario.
module test_sdr_cmd_ctrl;
    localparam int INIT   = 100;
    localparam int REFI   = 780;
    localparam int TRCD   = 3;
    localparam int TRP    = 3;
    localparam int TRC    = 9;
    localparam int TMRD   = 2;
    localparam int SLACK  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cas_lat3 = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [22:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic [15:0] sd_dq_in = '0;
    logic        req_ready, rd_valid, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic        sd_dq_oe;
    logic [15:0] rd_data, sd_dq_out;
    logic [1:0]  sd_ba, sd_dqm;
    logic [11:0] sd_addr;

    sdr_cmd_ctrl i_sdr_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .cas_lat3(cas_lat3),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
        .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out),
        .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor state
    int          cyc = 0;
    int          step, rel_cyc, pre_cyc, last_cyc, act_cyc, last_ref_cyc;
    int          ref_total = 0, act_total = 0, rd_cmd_cyc = 0, cl = 3;
    bit          ready_early, seq_err, pre_a10;
    logic [3:0]  code, last_cmd;
    logic [11:0] lmr_word;
    logic [1:0]  act_ba;
    logic [11:0] act_row;
    logic [15:0] word;
    logic [15:0] mem [int];
    // Expected host request, set by the host task
    logic [22:0] exp_addr = '0;
    logic [15:0] exp_wdata = '0;
    logic [1:0]  exp_mask = '0;

    task automatic drive_rd(input logic [15:0] d, input int lat);
        repeat (lat) @(posedge clk);
        #2 sd_dq_in = d;
        @(posedge clk);
        #2 sd_dq_in = 16'h0000;
    endtask

    always @(negedge clk) begin
        cyc++;
        code = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        if (!rst_n) begin
            step = 0; rel_cyc = cyc; last_cmd = 4'b0111; last_cyc = cyc;
            ready_early = 0; seq_err = 0; act_cyc = -1000; last_ref_cyc = cyc;
        end else begin
            if (step < 4 && req_ready) ready_early = 1;
            if (sd_dq_oe && code != 4'b0100) chk(0, "R6 oe outside write", 32'(code), 32'h4);
            if (code != 4'b0111) begin
                if (last_cmd == 4'b0001) chk(cyc - last_cyc >= TRC, "R9 gap after refresh", cyc - last_cyc, TRC);
                if (last_cmd == 4'b0010) chk(cyc - last_cyc >= TRP, "R9 gap after precharge", cyc - last_cyc, TRP);
                if (last_cmd == 4'b0000) chk(cyc - last_cyc >= TMRD, "R9 gap after mode", cyc - last_cyc, TMRD);
                case (code)
                    4'b0010: begin
                        if (step == 0) begin step = 1; pre_cyc = cyc; pre_a10 = sd_addr[10]; end
                        else seq_err = 1;
                    end
                    4'b0001: begin
                        if (step == 1 || step == 2) step++;
                        else if (step == 4) begin
                            chk(cyc - last_ref_cyc <= REFI + SLACK && cyc - last_ref_cyc >= REFI - SLACK,
                                "R7 refresh spacing", cyc - last_ref_cyc, REFI);
                            last_ref_cyc = cyc;
                            ref_total++;
                        end else seq_err = 1;
                    end
                    4'b0000: begin
                        if (step == 3) begin
                            step = 4; lmr_word = sd_addr; cl = int'(sd_addr[6:4]); last_ref_cyc = cyc;
                        end else seq_err = 1;
                    end
                    4'b0011: begin
                        if (step != 4) seq_err = 1;
                        chk(cyc - act_cyc >= TRC, "R9 act to act", cyc - act_cyc, TRC);
                        chk({sd_ba, sd_addr} == {exp_addr[22:21], exp_addr[20:9]}, "R3 active bank/row",
                            {sd_ba, sd_addr}, {exp_addr[22:21], exp_addr[20:9]});
                        act_cyc = cyc; act_ba = sd_ba; act_row = sd_addr; act_total++;
                    end
                    4'b0100, 4'b0101: begin
                        chk(cyc - act_cyc == TRCD, "R3 act to column delay", cyc - act_cyc, TRCD);
                        chk({sd_ba, sd_addr} == {act_ba, 3'b010, exp_addr[8:0]}, "R3 column word",
                            {sd_ba, sd_addr}, {act_ba, 3'b010, exp_addr[8:0]});
                        word = mem.exists({act_ba, act_row, sd_addr[8:0]}) ?
                               mem[{act_ba, act_row, sd_addr[8:0]}] : 16'h0000;
                        if (code == 4'b0100) begin
                            chk(sd_dqm == exp_mask && sd_dq_oe && sd_dq_out == exp_wdata, "R6 write data/mask",
                                {sd_dqm, sd_dq_oe, sd_dq_out}, {exp_mask, 1'b1, exp_wdata});
                            if (!sd_dqm[0]) word[7:0] = sd_dq_out[7:0];
                            if (!sd_dqm[1]) word[15:8] = sd_dq_out[15:8];
                            mem[{act_ba, act_row, sd_addr[8:0]}] = word;
                        end else begin
                            chk(sd_dqm == 2'b00, "R6 read mask low", 32'(sd_dqm), 0);
                            rd_cmd_cyc = cyc;
                            fork drive_rd(word, cl); join_none
                        end
                    end
                    default: seq_err = 1;
                endcase
                last_cmd = code; last_cyc = cyc;
            end
            if (rd_valid) chk(cyc - rd_cmd_cyc == cl + 1, "R5 read latency", cyc - rd_cmd_cyc, cl + 1);
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic reset_dut(input bit c3);
        tick();
        rst_n = 1'b0;
        cas_lat3 = c3;
        repeat (3) tick();
        rst_n = 1'b1;
    endtask

    task automatic host_req(input bit wr, input logic [22:0] a, input logic [15:0] d,
                            input logic [1:0] m);
        exp_addr = a; exp_wdata = d; exp_mask = m;
        req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        req_valid = 1'b1;
        while (!req_ready) tick();
        tick();
        req_valid = 1'b0;
    endtask

    task automatic do_read(input logic [22:0] a, input logic [15:0] exp, input string tag);
        int n = 0;
        host_req(1'b0, a, 16'h0, 2'b00);
        while (!rd_valid && n < 40) begin tick(); n++; end
        chk(rd_valid && rd_data == exp, tag, rd_data, exp);
        repeat (12) tick();
    endtask

    // R1 R2 R4: power-up order, encoding and the mode word
    task automatic t_init(input int cl_exp);
        int n = 0;
        chk(req_ready == 1'b0, "R1 ready low in reset", req_ready, 0);
        while (step != 4 && n < 3000) begin tick(); n++; end
        chk(step == 4, "R1 init sequence completes", step, 4);
        chk(pre_cyc - rel_cyc >= INIT, "R1 idle time before precharge", pre_cyc - rel_cyc, INIT);
        chk(pre_a10, "R1 precharge all uses bit 10", pre_a10, 1);
        chk(!seq_err, "R2 command order and codes", seq_err, 0);
        chk(!ready_early, "R1 ready held low during init", ready_early, 0);
        chk(sd_cke, "R1 clock enable high", sd_cke, 1);
        chk(lmr_word == {5'b0, 3'(cl_exp), 4'b0}, "R4 mode word", lmr_word, {5'b0, 3'(cl_exp), 4'b0});
        repeat (5) tick();
    endtask

    // R3 R5 R6: writes then reads across two banks
    task automatic t_write_read();
        host_req(1'b1, {2'd1, 12'hABC, 9'h123}, 16'hA55A, 2'b00);
        repeat (10) tick();
        host_req(1'b1, {2'd3, 12'h005, 9'h1FF}, 16'h1234, 2'b00);
        repeat (10) tick();
        do_read({2'd1, 12'hABC, 9'h123}, 16'hA55A, "R5 read back bank 1");
        do_read({2'd3, 12'h005, 9'h1FF}, 16'h1234, "R5 read back bank 3");
    endtask

    // R6: byte masks suppress bytes
    task automatic t_mask();
        host_req(1'b1, {2'd1, 12'hABC, 9'h123}, 16'hFFFF, 2'b01);
        repeat (10) tick();
        do_read({2'd1, 12'hABC, 9'h123}, 16'hFF5A, "R6 low byte masked");
        host_req(1'b1, {2'd1, 12'hABC, 9'h123}, 16'h0000, 2'b10);
        repeat (10) tick();
        do_read({2'd1, 12'hABC, 9'h123}, 16'hFF00, "R6 high byte masked");
    endtask

    // R7: idle refresh cadence
    task automatic t_refresh_idle();
        int r0 = ref_total;
        repeat (2 * REFI + 60) tick();
        chk(ref_total - r0 >= 2, "R7 refreshes while idle", ref_total - r0, 2);
    endtask

    // R8 R10: host never lets go while refreshes fall due
    task automatic t_flood();
        int r0 = ref_total;
        int a0 = act_total;
        int acc = 0;
        exp_addr = {2'd2, 12'h777, 9'h042};
        req_write = 1'b0; req_addr = exp_addr; req_valid = 1'b1;
        for (int i = 0; i < 2 * REFI + 200; i++) begin
            if (req_ready) acc++;
            tick();
        end
        req_valid = 1'b0;
        repeat (30) tick();
        chk(ref_total - r0 >= 2, "R8 refresh not starved", ref_total - r0, 2);
        chk(act_total - a0 == acc, "R10 one active per handshake", act_total - a0, acc);
        chk(acc >= 100, "R10 requests keep flowing", acc, 100);
    endtask

    // R4 R5: latency 2, and a later change of the select input is ignored
    task automatic t_cl2();
        host_req(1'b1, {2'd0, 12'h100, 9'h010}, 16'hC0DE, 2'b00);
        repeat (10) tick();
        cas_lat3 = 1'b1;
        do_read({2'd0, 12'h100, 9'h010}, 16'hC0DE, "R4 R5 read at latency 2");
        chk(cl == 2, "R4 latency stays as loaded", cl, 2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        reset_dut(1'b1);
        t_init(3);
        t_write_read();
        t_mask();
        t_refresh_idle();
        t_flood();
        reset_dut(1'b0);
        t_init(2);
        t_cl2();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule